// File: doc/BRIEF.md
# Three-Input Ternary Logic Unit

This block evaluates any Boolean function of three 64-bit operands, bit by bit. The function is given as an 8-entry truth table (an 8-bit immediate). The three operands are the present contents of the destination register and two source values. Every output bit looks up the table entry that the three matching operand bits address. The 64 bit positions are evaluated side by side, and no position depends on another.

An execution pipeline issues an operation by holding `start_i` high for one cycle, with the operands, the table and the record flag valid in that cycle. One cycle later the unit presents the new destination value and pulses `done_o`. When the record flag is set, the unit also writes a signed condition field derived from the result, and pulses a write enable beside it. Operations may be issued in consecutive cycles.

Top module: `tern_logic_unit`

## Requirements
- R1: While `rst_ni` is low, `result_o`, `cond_o`, `done_o` and `cond_we_o` are all zero.
- R2: Result bit i equals `lut_i[idx]` with idx = {dest_i[i], src_a_i[i], src_b_i[i]}, so the destination bit is the index MSB and the second source bit is the LSB.
- R3: A table of 0xFF gives all ones and a table of 0x00 gives all zeros, whatever the operands are.
- R4: A table of 0x80 gives the bitwise AND of the three operands. For example, 0x80000000FFFF0000, 0x80000000FF00FF00 and 0x80000000F0F0F0F0 give 0x80000000F0000000.
- R5: `done_o` is high for exactly the cycle after each cycle in which `start_i` is sampled high. `result_o` changes only in that cycle and holds its value otherwise.
- R6: When `rec_i` is high at start, `cond_we_o` pulses together with `done_o`. `cond_o` then reads the result as a signed value using bit 63: bit 3 = less than zero, bit 2 = greater than zero, bit 1 = equal to zero, and bit 0 = 0.
- R7: When `rec_i` is low at start, `cond_we_o` stays low and `cond_o` keeps the value of the last recorded operation.
- R8: Operations started in consecutive cycles each produce their own correct result in order.
- R9: Changes to operands, table or record flag while `start_i` is low have no effect on `result_o` or `cond_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Issue strobe; captures all operation inputs |
| rec_i | input | 1 | Record flag; update the condition field |
| lut_i | input | 8 | Truth table immediate |
| dest_i | input | 64 | Present destination contents (index MSB) |
| src_a_i | input | 64 | First source operand (middle index bit) |
| src_b_i | input | 64 | Second source operand (index LSB) |
| result_o | output | 64 | New destination value |
| done_o | output | 1 | Result-valid pulse |
| cond_o | output | 4 | Condition field {lt, gt, eq, 0} |
| cond_we_o | output | 1 | Condition field write enable |

## Verification
All 256 tables are applied to random operands. A mismatch there points to a wrong table entry or to a swapped index order, because random operands exercise all eight index values in almost every word. The constant tables 0x00 and 0xFF and the AND example with its set sign bits check for a stuck or inverted output. With recording on, results that are zero, positive and negative separate the eq, gt and lt bits. Recording off, back-to-back issue, and operand changes without a strobe each check the enable paths.

// File: rtl/tlu_pkg.sv
package tlu_pkg;
  localparam int NUM_OPS = 3;
  localparam int LUT_W   = 1 << NUM_OPS;
  localparam int COND_W  = 4;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic rsvd;
  } cond_t;
endpackage

// File: rtl/tlu_bit_eval.sv
module tlu_bit_eval
  import tlu_pkg::*;
(
  input  logic [LUT_W-1:0]   lut_i,
  input  logic [NUM_OPS-1:0] sel_i,
  output logic               bit_o
);
  assign bit_o = lut_i[sel_i];
endmodule

// File: rtl/tlu_cond_gen.sv
module tlu_cond_gen
  import tlu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] value_i,
  output cond_t             cond_o
);
  logic zero;
  logic neg;

  assign zero = (value_i == '0);
  assign neg  = value_i[DATA_W-1];

  always_comb begin
    cond_o      = '0;
    cond_o.lt   = neg;
    cond_o.gt   = !neg && !zero;
    cond_o.eq   = zero;
    cond_o.rsvd = 1'b0;
  end
endmodule

// File: rtl/tern_logic_unit.sv
module tern_logic_unit
  import tlu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 rec_i,
  input  logic [LUT_W-1:0]     lut_i,
  input  logic [DATA_W-1:0]    dest_i,
  input  logic [DATA_W-1:0]    src_a_i,
  input  logic [DATA_W-1:0]    src_b_i,
  output logic [DATA_W-1:0]    result_o,
  output logic                 done_o,
  output logic [COND_W-1:0]    cond_o,
  output logic                 cond_we_o
);
  logic [DATA_W-1:0] res_d;
  logic [DATA_W-1:0] res_q;
  cond_t             cond_d;
  cond_t             cond_q;
  logic              done_q;
  logic              cond_we_q;

  // one lookup per bit position, no cross-bit dependence
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    tlu_bit_eval i_bit (
      .lut_i (lut_i),
      .sel_i ({dest_i[i], src_a_i[i], src_b_i[i]}),
      .bit_o (res_d[i])
    );
  end

  tlu_cond_gen #(.DATA_W(DATA_W)) i_cond (
    .value_i (res_d),
    .cond_o  (cond_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q     <= '0;
      cond_q    <= '0;
      done_q    <= 1'b0;
      cond_we_q <= 1'b0;
    end else begin
      done_q    <= start_i;
      cond_we_q <= start_i && rec_i;
      if (start_i) res_q <= res_d;
      if (start_i && rec_i) cond_q <= cond_d;
    end
  end

  assign result_o  = res_q;
  assign done_o    = done_q;
  assign cond_o    = cond_q;
  assign cond_we_o = cond_we_q;
endmodule

// File: rtl/tlu_checker.sv
module tlu_checker
  import tlu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              rec_i,
  input logic [LUT_W-1:0]  lut_i,
  input logic [DATA_W-1:0] result_o,
  input logic              done_o,
  input logic [COND_W-1:0] cond_o,
  input logic              cond_we_o
);
  assert_done_after_start_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> done_o);
  assert_no_spurious_done_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !done_o);
  assert_result_held_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(result_o));
  assert_all_ones_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && lut_i == 8'hFF) |=> (result_o == {DATA_W{1'b1}}));
  assert_we_with_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cond_we_o |-> done_o);
  assert_cond_onehot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cond_we_o |-> ($countones(cond_o[3:1]) == 1 && !cond_o[0]));
  assert_cond_sign_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cond_we_o |-> (cond_o[3] == result_o[DATA_W-1]));
  assert_no_rec_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !rec_i) |=> (!cond_we_o && $stable(cond_o)));
endmodule

bind tern_logic_unit tlu_checker #(.DATA_W(DATA_W)) i_tlu_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .rec_i     (rec_i),
  .lut_i     (lut_i),
  .result_o  (result_o),
  .done_o    (done_o),
  .cond_o    (cond_o),
  .cond_we_o (cond_we_o)
);

// File: tb/test_tern_logic_unit.sv
module test_tern_logic_unit;
  localparam int DW = 64;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic          rec_i = 1'b0;
  logic [7:0]    lut_i = '0;
  logic [DW-1:0] dest_i = '0;
  logic [DW-1:0] src_a_i = '0;
  logic [DW-1:0] src_b_i = '0;
  logic [DW-1:0] result_o;
  logic          done_o;
  logic [3:0]    cond_o;
  logic          cond_we_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [DW-1:0] res;
    logic          rec;
    logic [3:0]    cond;
    string         tag;
  } exp_t;

  exp_t          sb_q[$];
  logic [3:0]    last_cond = '0;
  logic [DW-1:0] last_res = '0;

  always #10 clk_i = ~clk_i; // 50 MHz

  tern_logic_unit i_tern_logic_unit (
    .clk_i, .rst_ni, .start_i, .rec_i, .lut_i, .dest_i, .src_a_i, .src_b_i,
    .result_o, .done_o, .cond_o, .cond_we_o
  );

  function automatic logic [DW-1:0] ref_res(logic [DW-1:0] d, logic [DW-1:0] a,
                                            logic [DW-1:0] b, logic [7:0] lut);
    logic [DW-1:0] r;
    for (int i = 0; i < DW; i++) r[i] = lut[{d[i], a[i], b[i]}];
    return r;
  endfunction

  function automatic logic [3:0] ref_cond(logic [DW-1:0] r);
    logic eq, lt, gt;
    eq = (r == '0);
    lt = r[DW-1];
    gt = !eq && !lt;
    return {lt, gt, eq, 1'b0};
  endfunction

  task automatic check(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: leaves start high so consecutive calls issue back to back
  task automatic issue(logic [DW-1:0] d, logic [DW-1:0] a, logic [DW-1:0] b,
                       logic [7:0] lut, logic rec, string tag);
    exp_t e;
    @(negedge clk_i);
    dest_i = d; src_a_i = a; src_b_i = b; lut_i = lut; rec_i = rec;
    start_i = 1'b1;
    e.res  = ref_res(d, a, b, lut);
    e.rec  = rec;
    e.cond = ref_cond(e.res);
    e.tag  = tag;
    sb_q.push_back(e);
  endtask

  task automatic idle(int n);
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (n) @(negedge clk_i);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk_i);
      if (rst_ni) begin
        if (done_o) begin
          if (sb_q.size() == 0) begin
            check(1'b0, "R5 done without start", {63'd0, done_o}, '0);
          end else begin
            exp_t e;
            e = sb_q.pop_front();
            check(result_o === e.res, e.tag, result_o, e.res);
            check(cond_we_o === e.rec, "R6/R7 cond_we", {63'd0, cond_we_o}, {63'd0, e.rec});
            if (e.rec) begin
              check(cond_o === e.cond, "R6 cond", {60'd0, cond_o}, {60'd0, e.cond});
              last_cond = e.cond;
            end else begin
              check(cond_o === last_cond, "R7 cond kept", {60'd0, cond_o}, {60'd0, last_cond});
            end
            last_res = e.res;
          end
        end else begin
          check(cond_we_o === 1'b0, "R7 cond_we idle", {63'd0, cond_we_o}, '0);
        end
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!finished && cyc < 100000) begin
      @(posedge clk_i);
      cyc++;
    end
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d, a, b;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check(result_o === '0, "R1 result", result_o, '0);
    check(done_o === 1'b0, "R1 done", {63'd0, done_o}, '0);
    check(cond_o === '0, "R1 cond", {60'd0, cond_o}, '0);
    check(cond_we_o === 1'b0, "R1 cond_we", {63'd0, cond_we_o}, '0);
    rst_ni = 1'b1;
    idle(1);

    // R4 AND example with recording (negative result)
    issue(64'h80000000FFFF0000, 64'h80000000FF00FF00, 64'h80000000F0F0F0F0, 8'h80, 1'b1, "R4 and");
    idle(1);
    check(last_res === 64'h80000000F0000000, "R4 literal", last_res, 64'h80000000F0000000);

    // R3 constant tables
    issue({$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom}, 8'hFF, 1'b0, "R3 ones");
    issue('0, '0, '0, 8'hFF, 1'b1, "R3 ones zero ops");
    issue({$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom}, 8'h00, 1'b1, "R3 zeros");
    idle(1);

    // R6 zero, positive, negative results
    issue('0, '0, 64'h0000_0000_0000_0001, 8'hAA, 1'b1, "R6 positive");
    issue('0, '0, '0, 8'hAA, 1'b1, "R6 zero");
    issue('0, '0, 64'h8000_0000_0000_0000, 8'hAA, 1'b1, "R6 negative");
    // R7 no recording keeps last cond
    issue('0, '0, '0, 8'hAA, 1'b0, "R7 no record");
    idle(2);

    // R2 index order: single-operand selectors
    issue(64'hFFFF_0000_FFFF_0000, 64'h0F0F_0F0F_0F0F_0F0F, 64'h3333_3333_3333_3333, 8'hF0, 1'b0, "R2 dest msb");
    issue(64'hFFFF_0000_FFFF_0000, 64'h0F0F_0F0F_0F0F_0F0F, 64'h3333_3333_3333_3333, 8'hCC, 1'b0, "R2 src_a mid");
    issue(64'hFFFF_0000_FFFF_0000, 64'h0F0F_0F0F_0F0F_0F0F, 64'h3333_3333_3333_3333, 8'hAA, 1'b0, "R2 src_b lsb");
    idle(1);

    // R2/R8 all 256 tables, back to back, random operands
    for (int k = 0; k < 256; k++) begin
      issue({$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom},
            k[7:0], k[0], "R2 R8 sweep");
      if (k % 64 == 63) idle(1);
    end
    idle(2);

    // R9 inputs without strobe ignored
    d = {$urandom, $urandom}; a = {$urandom, $urandom}; b = {$urandom, $urandom};
    @(negedge clk_i);
    dest_i = d; src_a_i = a; src_b_i = b; lut_i = 8'h5A; rec_i = 1'b1;
    repeat (3) @(negedge clk_i);
    check(result_o === last_res, "R9 result ignored", result_o, last_res);
    check(cond_o === last_cond, "R9 cond ignored", {60'd0, cond_o}, {60'd0, last_cond});
    check(done_o === 1'b0, "R9 no done", {63'd0, done_o}, '0);

    idle(2);
    check(sb_q.size() == 0, "R5 pending results", sb_q.size(), '0);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule